// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker with Palette

This block takes 32-bit words fetched from a framebuffer and turns each one into a sequence of 24-bit RGB pixels. The packing depth is chosen by a three-bit depth code. It covers 1, 2, 4 and 8 bits per pixel through a 256-entry colour palette, direct 16-bit colour in several layouts, and 32-bit colour. Two ordering controls pick how pixels sit inside a word. A red/blue swap control selects the channel order.

Words arrive on a valid/ready stream. Pixels leave on a second valid/ready stream, at most one per cycle. The palette is filled through its own write port, one 32-bit word holding two 16-bit entries. A build-time parameter selects the extended variant. In that variant the depth code itself names the 16-bit layout. In the base variant, an external two-bit select decides how the 16-bit code is read.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is low and `in_ready` is high.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both high, and its first pixel is presented right after that edge. Each rising edge with `out_valid` and `out_ready` high moves to the next pixel. While `out_valid` is high and `out_ready` is low, `out_rgb` is held.
- R3: A word yields exactly 32/B pixels, where B is its depth in bits. `in_ready` is high only when no pixel is pending, or when the last pixel of the current word is being taken.
- R4: When both ordering bits are low, pixel k of a word comes from bits [k*B +: B], so the first pixel comes from the least significant end.
- R5: With `cfg_pix_be`=1 and `cfg_byte_be`=0, pixel k comes from slot 32/B-1-k, so the first pixel comes from the most significant end.
- R6: With `cfg_byte_be`=1, the four bytes of the word are first reversed (byte 0 swaps with byte 3, byte 1 with byte 2), and then pixels are taken from the least significant end. `cfg_pix_be` has no effect in this case.
- R7: Depth codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bits per pixel. The pixel value is an index into the palette. Palette write address a holds entry 2a in bits [15:0] and entry 2a+1 in bits [31:16]. An entry holds fields F0 in [4:0], F1 in [9:5] and F2 in [14:10]. Each field is shifted left by 3 to give 8 bits. Bit 15 of the entry is ignored.
- R8: A palette write takes effect for every lookup presented after the edge that performs it.
- R9: The output is {red, green, blue} in bits [23:16], [15:8] and [7:0]. Green is always the middle field. With `cfg_bgr`=0, red is the lowest field and blue the highest. With `cfg_bgr`=1, the two are exchanged.
- R10: Depth code 5 is 32 bits per pixel, with fields F0 in [7:0], F1 in [15:8] and F2 in [23:16], used unscaled. Bits [31:24] are ignored.
- R11: In the base variant, codes 4, 6 and 7 are 16 bits per pixel and are read according to `mux_sel`. With `mux_sel`=1 the layout is 5-5-5 (as in R7, bit 15 ignored). With `mux_sel`=0 or 2 the layout is 5-6-5 (F0 [4:0] shifted left 3, F1 [10:5] shifted left 2, F2 [15:11] shifted left 3) and honours `cfg_bgr`. With `mux_sel`=3 the layout is 5-6-5 with red and blue always exchanged.
- R12: In the extended variant, `mux_sel` is ignored. Code 4 is the 5-5-5 layout, code 6 is the 5-6-5 layout and code 7 is 4-4-4: fields at [3:0], [7:4] and [11:8], each shifted left 4. All three honour `cfg_bgr`, and all take 16 bits per pixel.
- R13: The depth, swap, ordering and select inputs are captured when a word is taken. Changing them while that word's pixels are still being emitted has no effect on those pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_depth | input | 3 | Depth / format code |
| cfg_bgr | input | 1 | Red/blue swap |
| cfg_byte_be | input | 1 | Reverse byte order within the word |
| cfg_pix_be | input | 1 | Take pixels from the most significant end |
| mux_sel | input | 2 | 16-bit layout select (base variant) |
| in_valid | input | 1 | Word available |
| in_word | input | 32 | Framebuffer word |
| in_ready | output | 1 | Word accepted this edge when valid |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 7 | Palette word address |
| pal_wdata | input | 32 | Two palette entries |
| out_valid | output | 1 | Pixel available |
| out_rgb | output | 24 | Pixel colour {red, green, blue} |
| out_ready | input | 1 | Pixel taken this edge when valid |

## Verification
A word's first pixel is due immediately after the edge that accepts it, and each further pixel follows one edge after the previous one is taken. A palette write is due to show on any lookup sampled after its edge. The driver computes every expected pixel of a word and queues it just before the accepting edge. The monitor compares a pixel on the falling edge preceding each handshake edge. Palette writes are issued only while nothing is in flight, so no queued expectation can go stale. A second instance built as the extended variant receives the same stimulus and is checked against its own queue.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int NBYTES      = WORD_W / BYTE_W;
    localparam int CH_W        = 8;
    localparam int RGB_W       = 3 * CH_W;
    localparam int PAL_ENTRIES = 256;
    localparam int ENTRY_W     = 16;
    localparam int PAL_AW      = $clog2(PAL_ENTRIES * ENTRY_W / WORD_W);
    localparam int PAL_IW      = $clog2(PAL_ENTRIES);
    localparam int IDX_W       = $clog2(WORD_W);
    localparam int LW_W        = 3;

    typedef enum logic [2:0] {
        FMT_IDX  = 3'd0,
        FMT_5551 = 3'd1,
        FMT_565  = 3'd2,
        FMT_444  = 3'd3,
        FMT_888  = 3'd4
    } fmt_e;

    typedef struct packed {
        fmt_e            fmt;
        logic            swap;
        logic [LW_W-1:0] lw;
        logic            bbe;
        logic            pbe;
    } pcfg_t;

    function automatic pcfg_t resolve_cfg(input logic [2:0] code, input logic [1:0] mux,
                                          input logic bgr, input logic bbe, input logic pbe,
                                          input logic ext);
        pcfg_t c;
        c.bbe  = bbe;
        c.pbe  = pbe & ~bbe;
        c.swap = bgr;
        c.lw   = 3'd4;
        c.fmt  = FMT_565;
        if (code <= 3'd3) begin
            c.lw  = code;
            c.fmt = FMT_IDX;
        end else if (code == 3'd5) begin
            c.lw  = 3'd5;
            c.fmt = FMT_888;
        end else if (ext) begin
            case (code)
                3'd4:    c.fmt = FMT_5551;
                3'd6:    c.fmt = FMT_565;
                default: c.fmt = FMT_444;
            endcase
        end else begin
            case (mux)
                2'd1:    c.fmt = FMT_5551;
                2'd3: begin
                    c.fmt  = FMT_565;
                    c.swap = 1'b1;
                end
                default: c.fmt = FMT_565;
            endcase
        end
        return c;
    endfunction

    function automatic logic [RGB_W-1:0] order_rgb(input logic [CH_W-1:0] lo,
                                                   input logic [CH_W-1:0] mid,
                                                   input logic [CH_W-1:0] hi,
                                                   input logic swap);
        return swap ? {hi, mid, lo} : {lo, mid, hi};
    endfunction
endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
    parameter int ENTRIES = 256,
    parameter int EW      = 16,
    parameter int WW      = 32,
    localparam int PER    = WW / EW,
    localparam int DEPTH  = ENTRIES / PER,
    localparam int AW     = $clog2(DEPTH),
    localparam int IW     = $clog2(ENTRIES),
    localparam int SW     = $clog2(PER)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [IW-1:0] rd_index,
    output logic [EW-1:0] rd_entry
);
    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] rd_word;
    logic [EW-1:0] lanes [PER];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rd_word = mem[rd_index[IW-1:SW]];

    for (genvar l = 0; l < PER; l++) begin : g_lane
        assign lanes[l] = rd_word[l*EW +: EW];
    end

    assign rd_entry = lanes[rd_index[SW-1:0]];
endmodule

// File: rtl/pxu_slot_sel.sv
module pxu_slot_sel
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LW_W-1:0]   lw,
    input  logic              bbe,
    input  logic              pbe,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] raw
);
    localparam int PW_W = IDX_W + 1;

    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] src;
    logic [PW_W-1:0]   npix;
    logic [PW_W-1:0]   width;
    logic [IDX_W-1:0]  slot;
    logic [IDX_W-1:0]  shamt;
    logic [WORD_W-1:0] mask;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[b*BYTE_W +: BYTE_W] = word[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        src   = bbe ? swapped : word;
        npix  = PW_W'(WORD_W) >> lw;
        width = PW_W'(1) << lw;
        slot  = pbe ? IDX_W'(npix - PW_W'(1) - PW_W'(idx)) : idx;
        shamt = slot << lw;
        mask  = ~({WORD_W{1'b1}} << width);
        raw   = (src >> shamt) & mask;
    end
endmodule

// File: rtl/pxu_color.sv
module pxu_color
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0]  raw,
    input  fmt_e               fmt,
    input  logic               swap,
    input  logic [ENTRY_W-1:0] pal_entry,
    output logic [PAL_IW-1:0]  pal_index,
    output logic [RGB_W-1:0]   rgb
);
    logic [CH_W-1:0] f0, f1, f2;

    assign pal_index = raw[PAL_IW-1:0];

    always_comb begin
        case (fmt)
            FMT_IDX: begin
                f0 = {pal_entry[4:0],   3'b0};
                f1 = {pal_entry[9:5],   3'b0};
                f2 = {pal_entry[14:10], 3'b0};
            end
            FMT_5551: begin
                f0 = {raw[4:0],   3'b0};
                f1 = {raw[9:5],   3'b0};
                f2 = {raw[14:10], 3'b0};
            end
            FMT_565: begin
                f0 = {raw[4:0],   3'b0};
                f1 = {raw[10:5],  2'b0};
                f2 = {raw[15:11], 3'b0};
            end
            FMT_444: begin
                f0 = {raw[3:0],  4'b0};
                f1 = {raw[7:4],  4'b0};
                f2 = {raw[11:8], 4'b0};
            end
            default: begin
                f0 = raw[7:0];
                f1 = raw[15:8];
                f2 = raw[23:16];
            end
        endcase
        rgb = order_rgb(f0, f1, f2, swap);
    end
endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker
    import pxu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_depth,
    input  logic              cfg_bgr,
    input  logic              cfg_byte_be,
    input  logic              cfg_pix_be,
    input  logic [1:0]        mux_sel,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_waddr,
    input  logic [WORD_W-1:0] pal_wdata,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb,
    input  logic              out_ready
);
    pcfg_t              cfg_q;
    logic [WORD_W-1:0]  word_q;
    logic               busy_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W:0]     npix;
    logic               last;
    logic               word_take;
    logic               pix_take;
    logic [WORD_W-1:0]  raw;
    logic [PAL_IW-1:0]  pal_index;
    logic [ENTRY_W-1:0] pal_entry;

    assign npix      = (IDX_W+1)'(WORD_W) >> cfg_q.lw;
    assign last      = (idx_q == IDX_W'(npix - 1'b1));
    assign in_ready  = ~busy_q | (out_ready & last);
    assign word_take = in_valid & in_ready;
    assign pix_take  = busy_q & out_ready;
    assign out_valid = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            word_q <= '0;
            cfg_q  <= '0;
        end else if (word_take) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            word_q <= in_word;
            cfg_q  <= resolve_cfg(cfg_depth, mux_sel, cfg_bgr, cfg_byte_be, cfg_pix_be, EXTENDED);
        end else if (pix_take) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
        end
    end

    pxu_slot_sel u_slot (
        .word (word_q),
        .lw   (cfg_q.lw),
        .bbe  (cfg_q.bbe),
        .pbe  (cfg_q.pbe),
        .idx  (idx_q),
        .raw  (raw)
    );

    pxu_palette #(.ENTRIES(PAL_ENTRIES), .EW(ENTRY_W), .WW(WORD_W)) u_pal (
        .clk      (clk),
        .we       (pal_we),
        .waddr    (pal_waddr),
        .wdata    (pal_wdata),
        .rd_index (pal_index),
        .rd_entry (pal_entry)
    );

    pxu_color u_color (
        .raw       (raw),
        .fmt       (cfg_q.fmt),
        .swap      (cfg_q.swap),
        .pal_entry (pal_entry),
        .pal_index (pal_index),
        .rgb       (out_rgb)
    );
endmodule

// File: rtl/fb_pixel_unpacker_chk.sv
module fb_pixel_unpacker_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        pal_we,
    input logic        out_valid,
    input logic [23:0] out_rgb,
    input logic        out_ready
);
    // R1: reset leaves no pixel pending
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    // R2: a stalled pixel holds its colour
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !pal_we |=> out_valid && $stable(out_rgb));

    // R2: an accepted word presents a pixel on the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R3: with nothing pending the input side is open
    p_idle_ready_r3: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R3: no new word while a pixel is stalled
    p_pending_block_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
endmodule

bind fb_pixel_unpacker fb_pixel_unpacker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pal_we    (pal_we),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_ready (out_ready)
);

// File: tb/sim_fb_pixel_unpacker.sv
`timescale 1ns/1ps
module sim_fb_pixel_unpacker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_depth = '0;
    logic        cfg_bgr = 1'b0, cfg_byte_be = 1'b0, cfg_pix_be = 1'b0;
    logic [1:0]  mux_sel = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        pal_we = 1'b0;
    logic [6:0]  pal_waddr = '0;
    logic [31:0] pal_wdata = '0;
    logic        out_ready = 1'b1;
    logic        in_ready0, in_ready1, out_valid0, out_valid1;
    logic [23:0] out_rgb0, out_rgb1;

    int total = 0, bad = 0, pushed = 0, popped = 0;
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] mpal [256];
    logic [23:0] q0[$], q1[$];
    string t0[$], t1[$];
    logic held0 = 1'b0, held1 = 1'b0;
    logic [23:0] hold0, hold1;

    always #2 clk = ~clk;

    fb_pixel_unpacker #(.EXTENDED(1'b0)) u0 (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
        .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be), .mux_sel(mux_sel),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready0),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .out_valid(out_valid0), .out_rgb(out_rgb0), .out_ready(out_ready));

    fb_pixel_unpacker #(.EXTENDED(1'b1)) u1 (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
        .cfg_byte_be(cfg_byte_be), .cfg_pix_be(cfg_pix_be), .mux_sel(mux_sel),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready1),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .out_valid(out_valid1), .out_rgb(out_rgb1), .out_ready(out_ready));

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pix(input logic [31:0] w, input logic [2:0] code,
                                            input logic bgr, input logic bbe, input logic pbe,
                                            input logic [1:0] mux, input bit ext, input int k);
        int lw, width, nper, slot, f;
        logic [31:0] s, raw;
        logic [7:0] a, b, c;
        logic sw;
        lw    = (code <= 3) ? int'(code) : (code == 5) ? 5 : 4;
        width = 1 << lw;
        nper  = 32 / width;
        s     = bbe ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        slot  = (!bbe && pbe) ? nper - 1 - k : k;
        raw   = s >> (slot * width);
        if (width < 32) raw = raw & ((32'h1 << width) - 1);
        sw = bgr;
        if (code <= 3) begin
            raw = {16'h0, mpal[raw[7:0]]};
            f = 1;
        end else if (code == 5) f = 4;
        else if (ext) f = (code == 4) ? 1 : (code == 6) ? 2 : 3;
        else begin
            case (mux)
                2'd1: f = 1;
                2'd3: begin f = 2; sw = 1'b1; end
                default: f = 2;
            endcase
        end
        case (f)
            1: begin a = {raw[4:0], 3'b0}; b = {raw[9:5], 3'b0};  c = {raw[14:10], 3'b0}; end
            2: begin a = {raw[4:0], 3'b0}; b = {raw[10:5], 2'b0}; c = {raw[15:11], 3'b0}; end
            3: begin a = {raw[3:0], 4'b0}; b = {raw[7:4], 4'b0};  c = {raw[11:8], 4'b0}; end
            default: begin a = raw[7:0]; b = raw[15:8]; c = raw[23:16]; end
        endcase
        return sw ? {c, b, a} : {a, b, c};
    endfunction

    // called on a falling edge; returns on a falling edge
    task automatic send(input logic [31:0] w, input logic [2:0] code, input logic bgr,
                        input logic bbe, input logic pbe, input logic [1:0] mux, input string tag);
        int lw, nper;
        cfg_depth = code; cfg_bgr = bgr; cfg_byte_be = bbe; cfg_pix_be = pbe; mux_sel = mux;
        in_word = w; in_valid = 1'b1;
        while (!in_ready0) @(negedge clk);
        lw   = (code <= 3) ? int'(code) : (code == 5) ? 5 : 4;
        nper = 32 >> lw;
        for (int k = 0; k < nper; k++) begin
            q0.push_back(exp_pix(w, code, bgr, bbe, pbe, mux, 1'b0, k)); t0.push_back(tag);
            q1.push_back(exp_pix(w, code, bgr, bbe, pbe, mux, 1'b1, k)); t1.push_back(tag);
            pushed++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pal_write(input int a, input logic [31:0] d);
        pal_we = 1'b1; pal_waddr = 7'(a); pal_wdata = d;
        @(negedge clk);
        pal_we = 1'b0;
        mpal[2*a]   = d[15:0];
        mpal[2*a+1] = d[31:16];
    endtask

    task automatic wait_idle();
        while (q0.size() != 0 || q1.size() != 0 || out_valid0 || out_valid1) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (rmode == 0) ? 1'b1 : (lfsr[1] | lfsr[4]);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (held0 && out_valid0) check(out_rgb0 == hold0, "R2 stall hold u0", {8'h0, out_rgb0}, {8'h0, hold0});
            if (held1 && out_valid1) check(out_rgb1 == hold1, "R2 stall hold u1", {8'h0, out_rgb1}, {8'h0, hold1});
            if (out_valid0 && out_ready) begin
                if (q0.size() == 0) check(1'b0, "R3 extra pixel u0", {8'h0, out_rgb0}, 32'h0);
                else begin
                    logic [23:0] e;
                    string tg;
                    e = q0.pop_front(); tg = t0.pop_front(); popped++;
                    check(out_rgb0 == e, {tg, " base"}, {8'h0, out_rgb0}, {8'h0, e});
                end
            end
            if (out_valid1 && out_ready) begin
                if (q1.size() == 0) check(1'b0, "R3 extra pixel u1", {8'h0, out_rgb1}, 32'h0);
                else begin
                    logic [23:0] e;
                    string tg;
                    e = q1.pop_front(); tg = t1.pop_front();
                    check(out_rgb1 == e, {tg, " ext"}, {8'h0, out_rgb1}, {8'h0, e});
                end
            end
            held0 = out_valid0 && !out_ready; hold0 = out_rgb0;
            held1 = out_valid1 && !out_ready; hold1 = out_rgb1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!out_valid0 && in_ready0, "R1 reset state u0", {30'h0, out_valid0, in_ready0}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid0 && in_ready0, "R1 after reset u0", {30'h0, out_valid0, in_ready0}, 32'h1);
        check(!out_valid1 && in_ready1, "R1 after reset u1", {30'h0, out_valid1, in_ready1}, 32'h1);

        for (int i = 0; i < 128; i++)
            pal_write(i, {16'(i * 16'h9E37 ^ 16'hA5C3), 16'(i * 16'h3B1D ^ 16'h5A5A)});

        rmode = 0;
        send(32'h12345678, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        send(32'hA1B2C3D4, 3'd5, 1'b1, 1'b0, 1'b0, 2'd0, "R9");
        send(32'h80FF017F, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
        send(32'hFF807F01, 3'd3, 1'b1, 1'b0, 1'b0, 2'd0, "R9");
        send(32'h0F1E2D3C, 3'd3, 1'b0, 1'b0, 1'b1, 2'd0, "R5");
        send(32'hC0FFEE11, 3'd3, 1'b0, 1'b1, 1'b0, 2'd0, "R6");
        send(32'hC0FFEE11, 3'd3, 1'b0, 1'b1, 1'b1, 2'd0, "R6");
        send(32'h80000001, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, "R4");
        send(32'h80000003, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, "R5");
        send(32'hE4E41B1B, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, "R3");
        send(32'h76543210, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, "R4");
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 2; b++)
                send(32'hDEADBEEF, 3'd4, 1'(b), 1'b0, 1'b0, 2'(m), "R11");
        send(32'h1234FEDC, 3'd4, 1'b0, 1'b1, 1'b0, 2'd1, "R6");
        send(32'h0FA55AF0, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1, "R12");
        send(32'h0FA55AF0, 3'd7, 1'b0, 1'b0, 1'b0, 2'd3, "R12");
        send(32'h9ABC1357, 3'd7, 1'b1, 1'b0, 1'b1, 2'd0, "R12");

        rmode = 1;
        for (int r = 0; r < 6; r++) begin
            send(32'h13579BDF ^ 32'(r * 32'h01010101), 3'(r % 4), 1'(r % 2), 1'b0, 1'(r % 3 == 0), 2'(r), "R13");
            send(32'hFEDCBA98 + 32'(r), 3'd5, 1'(r % 2 == 0), 1'(r % 2), 1'b0, 2'd0, "R2");
            send(32'h2468ACE0 ^ 32'(r), 3'd4, 1'b0, 1'b0, 1'b1, 2'(3 - r % 4), "R13");
        end

        wait_idle();
        rmode = 0;
        @(negedge clk);
        pal_write(5, 32'hFFFF7C1F);
        send(32'h0B0A0B0A, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, "R8");
        send(32'h0A0B0A0B, 3'd3, 1'b1, 1'b0, 1'b0, 2'd0, "R8");

        wait_idle();
        repeat (3) @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0 && popped == pushed, "R3 pixel count",
              32'(popped), 32'(pushed));
        check(!out_valid0 && in_ready0, "R3 idle after drain", {30'h0, out_valid0, in_ready0}, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule